// File: doc/BRIEF.md
# Address-Event Ring Node Router

This block routes spike events for one board on a ring of address-event boards. Each event is a 16-bit word. The upper 3 bits hold a chip code and the lower 13 bits hold a neuron address. Codes with the top bit clear mark events going into a chip. Codes with the top bit set mark events coming out of a chip. The code's two low bits give the ring position: 0 is the retina or sequencer slot, and 1 to 3 are the other chips.

Every event that arrives on the ring input is forwarded to the ring output. If its code equals the node's configured input code, the node also hands the neuron address to the local chip.

The node also handles events from the local chip. It stamps each one with the node's output code and merges it onto the ring.

One board per ring runs in channel-0 mode. In this mode the node takes host events and injects them onto the ring. It also stops forwarding input-coded events, so that mapped events never return to the mapper and stall the ring.

An optional filter drops input events that address synapse 0 of a neuron whose Y coordinate is 2 or 3 modulo 4. The node counts the events it drops this way.

Top module: `aer_ring_node`

## Requirements
- R1: A ring input word is forwarded to `ser_out_data` bit-for-bit unchanged, unless R5 or R7 removes it.
- R2: A ring input word whose bits [15:13] equal `cfg_in_code` is also delivered once on `chip_out_addr`, as bits [12:0] of the word.
- R3: A ring input word whose bits [15:13] differ from `cfg_in_code` never appears on the chip output.
- R4: A local chip event with address A leaves on the ring as {`cfg_out_code`, A}.
- R5: With `cfg_chan0` set, a ring input word with bit 15 clear is not forwarded. It is still delivered to the chip if R2 applies.
- R6: With `cfg_chan0` clear, `host_ready` stays low and host words have no effect on any output. With it set, a host word is forwarded unchanged.
- R7: With `cfg_filt_en` set, a ring input word is dropped from both outputs when all three hold: bit 15 is clear, the synapse field is zero, and bit 1 of the Y field is set. With the default parameters the synapse field is bits [1:0] and the Y field starts at bit 7, so the condition is bit 8 set.
- R8: `filt_cnt` goes up by one for each word R7 drops and stops at its maximum of 255 by default.
- R9: Pass-through, local and host sources share the ring output in round-robin order. After reset, pass-through has first priority.
- R10: A ring input word is accepted only when both the pass-through FIFO and the chip FIFO have room. No word is lost, duplicated or reordered while either output is stalled.
- R11: While `ser_out_valid` is high and `ser_out_ready` is low, `ser_out_data` holds its value.
- R12: After a synchronous reset, both output valids are low, `filt_cnt` is 0 and `ser_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_code | input | 3 | Code that marks events for this node's chip |
| cfg_out_code | input | 3 | Code stamped onto this node's chip events |
| cfg_chan0 | input | 1 | Channel-0 mode: host injection and input-event suppression |
| cfg_filt_en | input | 1 | Enables the illegal-event filter |
| ser_in_valid | input | 1 | Ring input word valid |
| ser_in_data | input | 16 | Ring input word |
| ser_in_ready | output | 1 | Ring input can accept a word |
| ser_out_valid | output | 1 | Ring output word valid |
| ser_out_data | output | 16 | Ring output word |
| ser_out_ready | input | 1 | Next node accepts the ring output word |
| chip_out_valid | output | 1 | Address for the local chip valid |
| chip_out_addr | output | 13 | Neuron address for the local chip |
| chip_out_ready | input | 1 | Local chip accepts the address |
| chip_in_valid | input | 1 | Local chip event valid |
| chip_in_addr | input | 13 | Local chip neuron address |
| chip_in_ready | output | 1 | Node accepts the local chip event |
| host_valid | input | 1 | Host event valid |
| host_data | input | 16 | Host event word |
| host_ready | output | 1 | Node accepts the host event |
| filt_cnt | output | 8 | Saturating count of filtered words |

## Verification
The routing decision is tested with a table of ring words. The table covers a matching input code, a non-matching input code and an output code, each with channel-0 mode on and off. This shows that forwarding and chip delivery are decided independently of each other.

Filter cases change one condition at a time: Y modulo 4 of 1, 2 and 3, synapse zero versus nonzero, the filter disabled, and an output-coded word. Each case shows that all three conditions are needed before a word is dropped.

Directed runs stall each output in turn to check admission and ordering. One run fills all three sources at once to check the grant rotation. Another sends a long burst of illegal words to check that the counter saturates.

// File: rtl/aer_node_pkg.sv
package aer_node_pkg;
  localparam int CODE_W  = 3;
  localparam int NRN_W   = 13;
  localparam int EVT_W   = CODE_W + NRN_W;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_PASS  = 2'd0,
    SRC_LOCAL = 2'd1,
    SRC_HOST  = 2'd2
  } src_e;
endpackage

// File: rtl/aer_evt_fifo.sv
module aer_evt_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/aer_rr_arb.sv
module aer_rr_arb #(
  parameter int N = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          req,
  input  logic                  adv,
  output logic [N-1:0]          gnt,
  output logic [$clog2(N)-1:0]  gnt_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    found   = 1'b0;
    gnt_idx = last_q;
    gnt     = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!found && req[c]) begin
        found   = 1'b1;
        gnt_idx = IW'(c);
      end
    end
    if (found) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                last_q <= IW'(N - 1);
    else if (adv && found)  last_q <= gnt_idx;
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R9
  grant_on_req_chk: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|(gnt & req)));
endmodule

// File: rtl/aer_ring_node.sv
module aer_ring_node
  import aer_node_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int Y_LSB      = 7,
  parameter int SYN_LSB    = 0,
  parameter int SYN_W      = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cfg_in_code,
  input  logic [CODE_W-1:0] cfg_out_code,
  input  logic              cfg_chan0,
  input  logic              cfg_filt_en,
  input  logic              ser_in_valid,
  input  logic [EVT_W-1:0]  ser_in_data,
  output logic              ser_in_ready,
  output logic              ser_out_valid,
  output logic [EVT_W-1:0]  ser_out_data,
  input  logic              ser_out_ready,
  output logic              chip_out_valid,
  output logic [NRN_W-1:0]  chip_out_addr,
  input  logic              chip_out_ready,
  input  logic              chip_in_valid,
  input  logic [NRN_W-1:0]  chip_in_addr,
  output logic              chip_in_ready,
  input  logic              host_valid,
  input  logic [EVT_W-1:0]  host_data,
  output logic              host_ready,
  output logic [CNT_W-1:0]  filt_cnt
);
  localparam int IW = $clog2(NUM_SRC);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // ring input decode
  logic [CODE_W-1:0] in_code;
  logic is_input, hit_chip, illegal, take;
  logic chipq_full, chipq_empty, chipq_push;

  assign in_code  = ser_in_data[EVT_W-1 -: CODE_W];
  assign is_input = !in_code[CODE_W-1];
  assign hit_chip = (in_code == cfg_in_code);
  assign illegal  = cfg_filt_en && is_input &&
                    (ser_in_data[SYN_LSB +: SYN_W] == '0) && ser_in_data[Y_LSB + 1];

  // per-source queues feeding the ring output
  logic [NUM_SRC-1:0] src_push, src_pop, src_full, src_empty, gnt;
  logic [EVT_W-1:0]   src_wdata [NUM_SRC];
  logic [EVT_W-1:0]   src_head  [NUM_SRC];
  logic [IW-1:0]      gnt_idx;
  logic               out_free, adv;

  assign ser_in_ready  = !src_full[SRC_PASS] && !chipq_full;
  assign take          = ser_in_valid && ser_in_ready;
  assign chipq_push    = take && !illegal && hit_chip;

  assign chip_in_ready = !src_full[SRC_LOCAL];
  assign host_ready    = cfg_chan0 && !src_full[SRC_HOST];

  assign src_push[SRC_PASS]   = take && !illegal && !(cfg_chan0 && is_input);
  assign src_wdata[SRC_PASS]  = ser_in_data;
  assign src_push[SRC_LOCAL]  = chip_in_valid && chip_in_ready;
  assign src_wdata[SRC_LOCAL] = {cfg_out_code, chip_in_addr};
  assign src_push[SRC_HOST]   = host_valid && host_ready;
  assign src_wdata[SRC_HOST]  = host_data;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    aer_evt_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk   (clk),
      .rst   (rst),
      .push  (src_push[s]),
      .wdata (src_wdata[s]),
      .pop   (src_pop[s]),
      .head  (src_head[s]),
      .full  (src_full[s]),
      .empty (src_empty[s])
    );
  end

  aer_evt_fifo #(.W(NRN_W), .DEPTH(FIFO_DEPTH)) chipq_i (
    .clk   (clk),
    .rst   (rst),
    .push  (chipq_push),
    .wdata (ser_in_data[NRN_W-1:0]),
    .pop   (chip_out_valid && chip_out_ready),
    .head  (chip_out_addr),
    .full  (chipq_full),
    .empty (chipq_empty)
  );
  assign chip_out_valid = !chipq_empty;

  // ring output: round-robin into one output register
  assign out_free = !ser_out_valid || ser_out_ready;
  assign adv      = out_free && !(&src_empty);
  assign src_pop  = adv ? gnt : '0;

  aer_rr_arb #(.N(NUM_SRC)) arb_i (
    .clk     (clk),
    .rst     (rst),
    .req     (~src_empty),
    .adv     (adv),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out_valid <= 1'b0;
      ser_out_data  <= '0;
    end else if (adv) begin
      ser_out_valid <= 1'b1;
      ser_out_data  <= src_head[gnt_idx];
    end else if (ser_out_ready) begin
      ser_out_valid <= 1'b0;
    end
  end

  // filtered-word counter
  always_ff @(posedge clk) begin
    if (rst)                                     filt_cnt <= '0;
    else if (take && illegal && filt_cnt != CNT_MAX) filt_cnt <= filt_cnt + 1'b1;
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_out_valid && !ser_out_ready) |=> (ser_out_valid && $stable(ser_out_data)));
  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_cnt == CNT_MAX) |=> (filt_cnt == CNT_MAX));
  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 (filt_cnt >= $past(filt_cnt)));
endmodule

// File: tb/aer_ring_node_tb_top.sv
`timescale 1ns/1ps
module aer_ring_node_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_in_code  = 3'b010;
  logic [2:0]  cfg_out_code = 3'b110;
  logic        cfg_chan0 = 1'b0, cfg_filt_en = 1'b0;
  logic        ser_in_valid = 1'b0;
  logic [15:0] ser_in_data = '0;
  logic        ser_in_ready;
  logic        ser_out_valid;
  logic [15:0] ser_out_data;
  logic        ser_out_ready = 1'b1;
  logic        chip_out_valid;
  logic [12:0] chip_out_addr;
  logic        chip_out_ready = 1'b1;
  logic        chip_in_valid = 1'b0;
  logic [12:0] chip_in_addr = '0;
  logic        chip_in_ready;
  logic        host_valid = 1'b0;
  logic [15:0] host_data = '0;
  logic        host_ready;
  logic [7:0]  filt_cnt;

  always #2 clk = ~clk;

  aer_ring_node dut_i (.*);

  int tests = 0, fails = 0;
  int fwd_n = 0, chip_n = 0;
  logic [15:0] fwd_log  [64];
  logic [12:0] chip_log [64];

  always @(posedge clk) begin
    if (!rst && ser_out_valid && ser_out_ready) begin
      fwd_log[fwd_n % 64] = ser_out_data;
      fwd_n = fwd_n + 1;
    end
    if (!rst && chip_out_valid && chip_out_ready) begin
      chip_log[chip_n % 64] = chip_out_addr;
      chip_n = chip_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_ser(input logic [15:0] w);
    @(negedge clk);
    ser_in_valid = 1'b1;
    ser_in_data  = w;
    while (!ser_in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ser_in_valid = 1'b0;
  endtask

  // {word, chan0, filt_en, exp_fwd, exp_chip, exp_filt}
  localparam logic [20:0] VEC [12] = '{
    {16'h4123, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 R2 match
    {16'h2055, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 other input code
    {16'hC0AA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 output code
    {16'h4123, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 suppressed, still to chip
    {16'hA001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 output code passes
    {16'h4100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 y=2 syn=0
    {16'h2180, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 y=3 syn=0
    {16'h4101, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 syn=1 passes
    {16'h4080, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 y=1 passes
    {16'h4100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R7 filter off
    {16'hC100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R7 output code not filtered
    {16'h0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}   // R7 R5 dropped under chan0
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int f0, c0, k0;
    logic [15:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!ser_out_valid, "R12 ser_out_valid", ser_out_valid, 0);
    check(!chip_out_valid, "R12 chip_out_valid", chip_out_valid, 0);
    check(filt_cnt == 0, "R12 filt_cnt", filt_cnt, 0);
    check(ser_in_ready, "R12 ser_in_ready", ser_in_ready, 1);

    // table of routing vectors
    for (int i = 0; i < 12; i++) begin
      logic [15:0] w;
      w = VEC[i][20:5];
      cfg_chan0   = VEC[i][4];
      cfg_filt_en = VEC[i][3];
      f0 = fwd_n; c0 = chip_n; k0 = filt_cnt;
      send_ser(w);
      repeat (6) @(negedge clk);
      check((fwd_n - f0) == int'(VEC[i][2]), "R1 R5 R7 forward count", fwd_n - f0, VEC[i][2]);
      if (VEC[i][2]) check(fwd_log[f0 % 64] == w, "R1 forward word", fwd_log[f0 % 64], w);
      check((chip_n - c0) == int'(VEC[i][1]), "R2 R3 chip count", chip_n - c0, VEC[i][1]);
      if (VEC[i][1]) check(chip_log[c0 % 64] == w[12:0], "R2 chip addr", chip_log[c0 % 64], w[12:0]);
      check((int'(filt_cnt) - k0) == int'(VEC[i][0]), "R8 filt_cnt step", int'(filt_cnt) - k0, VEC[i][0]);
    end
    cfg_chan0 = 1'b0; cfg_filt_en = 1'b0;

    // R4 local stamping
    f0 = fwd_n;
    @(negedge clk); chip_in_valid = 1'b1; chip_in_addr = 13'h1ABC;
    @(negedge clk); chip_in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(fwd_n - f0 == 1, "R4 local count", fwd_n - f0, 1);
    check(fwd_log[f0 % 64] == 16'hDABC, "R4 stamped word", fwd_log[f0 % 64], 16'hDABC);

    // R6 host ignored without chan0
    f0 = fwd_n;
    @(negedge clk); host_valid = 1'b1; host_data = 16'h1234;
    repeat (4) begin
      @(negedge clk);
      check(!host_ready, "R6 host_ready low", host_ready, 0);
    end
    host_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(fwd_n == f0, "R6 host ignored", fwd_n - f0, 0);
    // R6 host injected with chan0
    cfg_chan0 = 1'b1;
    @(negedge clk); host_valid = 1'b1;
    while (!host_ready) @(negedge clk);
    @(negedge clk); host_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(fwd_n - f0 == 1, "R6 host count", fwd_n - f0, 1);
    check(fwd_log[f0 % 64] == 16'h1234, "R6 host word", fwd_log[f0 % 64], 16'h1234);

    // R9 round robin: fill all sources while output stalled
    f0 = fwd_n;
    ser_out_ready = 1'b0;
    send_ser(16'h8001);
    send_ser(16'h8002);
    @(negedge clk); chip_in_valid = 1'b1; chip_in_addr = 13'h0011;
    @(negedge clk); chip_in_addr = 13'h0012;
    @(negedge clk); chip_in_valid = 1'b0; host_valid = 1'b1; host_data = 16'h0A01;
    @(negedge clk); host_data = 16'h0A02;
    @(negedge clk); host_valid = 1'b0;
    ser_out_ready = 1'b1;
    repeat (10) @(negedge clk);
    check(fwd_n - f0 == 6, "R9 count", fwd_n - f0, 6);
    check(fwd_log[(f0+0) % 64] == 16'h8001, "R9 order 0", fwd_log[(f0+0) % 64], 16'h8001);
    check(fwd_log[(f0+1) % 64] == 16'hC011, "R9 order 1", fwd_log[(f0+1) % 64], 16'hC011);
    check(fwd_log[(f0+2) % 64] == 16'h0A01, "R9 order 2", fwd_log[(f0+2) % 64], 16'h0A01);
    check(fwd_log[(f0+3) % 64] == 16'h8002, "R9 order 3", fwd_log[(f0+3) % 64], 16'h8002);
    check(fwd_log[(f0+4) % 64] == 16'hC012, "R9 order 4", fwd_log[(f0+4) % 64], 16'hC012);
    check(fwd_log[(f0+5) % 64] == 16'h0A02, "R9 order 5", fwd_log[(f0+5) % 64], 16'h0A02);
    cfg_chan0 = 1'b0;

    // R10 R11 ring output stalled
    f0 = fwd_n;
    ser_out_ready = 1'b0;
    for (int i = 1; i <= 5; i++) send_ser(16'h8000 + 16'(i));
    @(negedge clk);
    held = ser_out_data;
    ser_in_valid = 1'b1; ser_in_data = 16'h8006;
    repeat (3) @(negedge clk);
    check(!ser_in_ready, "R10 ready low when pass full", ser_in_ready, 0);
    check(ser_out_valid && ser_out_data == held, "R11 held data", ser_out_data, held);
    ser_in_valid = 1'b0;
    ser_out_ready = 1'b1;
    repeat (10) @(negedge clk);
    check(fwd_n - f0 == 5, "R10 no loss count", fwd_n - f0, 5);
    for (int i = 0; i < 5; i++)
      check(fwd_log[(f0+i) % 64] == 16'h8001 + 16'(i), "R10 order", fwd_log[(f0+i) % 64], 16'h8001 + 16'(i));

    // R10 chip output stalled
    f0 = fwd_n; c0 = chip_n;
    chip_out_ready = 1'b0;
    for (int i = 1; i <= 4; i++) send_ser(16'h4000 + 16'(i));
    @(negedge clk);
    ser_in_valid = 1'b1; ser_in_data = 16'h4005;
    repeat (3) @(negedge clk);
    check(!ser_in_ready, "R10 ready low when chip full", ser_in_ready, 0);
    check(fwd_n - f0 == 4, "R10 forward while chip stalled", fwd_n - f0, 4);
    ser_in_valid = 1'b0;
    chip_out_ready = 1'b1;
    repeat (8) @(negedge clk);
    check(chip_n - c0 == 4, "R10 chip count", chip_n - c0, 4);
    for (int i = 0; i < 4; i++)
      check(chip_log[(c0+i) % 64] == 13'h0001 + 13'(i), "R10 chip order", chip_log[(c0+i) % 64], 13'h0001 + 13'(i));

    // R8 saturation
    cfg_filt_en = 1'b1;
    @(negedge clk);
    ser_in_valid = 1'b1; ser_in_data = 16'h4100;
    repeat (260) @(negedge clk);
    ser_in_valid = 1'b0;
    @(negedge clk);
    check(filt_cnt == 8'hFF, "R8 saturated", filt_cnt, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule